// File: doc/BRIEF.md
# Bus-Master IDE DMA Register Block

This block holds the software-visible registers that steer bus-master DMA on a two-channel IDE controller. It answers a 16-byte I/O window. The window splits into one 8-byte slice per channel. Each slice carries a command byte, a status byte and a 32-bit pointer to the channel's descriptor table. A host register bus reaches the registers. The bus gives a dword address, byte enables, write data, and separate one-cycle read and write strobes. Read data comes back registered.

Per channel, the DMA engine next to this block sees the start/stop bit, the direction bit and the aligned descriptor pointer on dedicated outputs. It reports back in three ways: a level that says a transfer is running, a one-cycle pulse that sets the error flag, and a one-cycle pulse that sets the interrupt flag. Software clears the two flags by writing ones to them. It also owns two free read/write status bits. The running flag is mirrored and cannot be written.

Top module: `ide_bm_regs`

## Requirements
- R1: `bus_addr` carries byte-address bits [3:2]. Bit 3 picks the channel and bit 2 picks the dword (0 = command/status, 1 = descriptor pointer). `bus_rdata` loads at the clock edge that samples `bus_rd` and holds its value while no read is issued.
- R2: Byte lane 0 of dword 0 is the command register. Bit 0 (start) and bit 3 (direction) are stored and drive `dma_start` and `dma_dir`. All other command bits read as zero.
- R3: Byte lanes 1 and 3 of dword 0 read as 0xFF.
- R4: Byte lane 2 of dword 0 is the status register. A write with byte enable 2 set loads status bits 5 and 6 from the written data.
- R5: Status bit 0 shows `dma_active` as it was one clock edge earlier. A status write never changes it.
- R6: Status bit 1 (error) is set by an `err_set` pulse and bit 2 (interrupt) by an `irq_set` pulse. A written 1 clears either bit and a written 0 leaves it as it is. When a set pulse and a clearing write land in the same cycle, the set wins.
- R7: Status bits 3, 4 and 7 always read as zero.
- R8: Dword 1 is the descriptor pointer and takes writes lane by lane under the byte enables. Bits [1:0] are always zero. The stored value drives `prd_addr` (channel 0 in bits [31:0]).
- R9: Reset clears command, status and pointer registers in both channels, and clears `bus_rdata`.
- R10: Accesses to one channel leave the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W-2 (2) | Byte-address bits [ADDR_W-1:2] of the access |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| dma_active | input | NUM_CH | Per-channel transfer-running level from the DMA engine |
| err_set | input | NUM_CH | Per-channel pulse that sets the error flag |
| irq_set | input | NUM_CH | Per-channel pulse that sets the interrupt flag |
| dma_start | output | NUM_CH | Per-channel start/stop command bit |
| dma_dir | output | NUM_CH | Per-channel direction command bit |
| prd_addr | output | 32*NUM_CH | Per-channel descriptor-table pointer |

## Verification
A write, an `err_set` or an `irq_set` pulse updates the registers at the rising edge that samples it. A read strobed in the following cycle therefore sees the new value. Read data is due one edge after the read strobe, so the bench raises `bus_rd` on a falling edge and samples `bus_rdata` on the next falling edge. Status bit 0 trails `dma_active` by one edge, so the bench waits two edges after changing that input before it reads. Same-cycle races between a hardware set and a software clear are driven on the same falling edge so both reach one rising edge.

// File: rtl/ide_bm_pkg.sv
// Package: shared constants, status layout and the pointer merge helper
// for the bus-master IDE DMA register block.
// Assumes 32-bit data path with four byte lanes.
package ide_bm_pkg;

    localparam int CH_BYTES      = 8;
    localparam int CH_OFS_W      = $clog2(CH_BYTES);
    localparam int LANE_CMD      = 0;
    localparam int LANE_STAT     = 2;
    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACT_BIT    = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_IRQ_BIT    = 2;
    localparam int ST_FREE_LO    = 5;
    localparam logic [7:0] PAD_BYTE = 8'hFF;

    // Status byte as software sees it, most significant bit first.
    typedef struct packed {
        logic       rsv7;
        logic [1:0] free;
        logic [1:0] rsv43;
        logic       irq;
        logic       err;
        logic       act;
    } stat_t;

    // Merge byte-enabled write data into the pointer; low two bits stay zero.
    function automatic logic [31:2] ptr_merge(input logic [31:2] old,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be);
        logic [31:0] full;
        full = {old, 2'b00};
        for (int i = 0; i < 4; i++) begin
            if (be[i]) full[8*i +: 8] = wd[8*i +: 8];
        end
        return full[31:2];
    endfunction

endpackage

// File: rtl/ide_bm_chan.sv
// Module: one channel's command, status and descriptor-pointer registers.
// Assumes ctl_wr / ptr_wr are already decoded to this channel and are
// one-cycle strobes; hardware set pulses override a same-cycle clear.
module ide_bm_chan
    import ide_bm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        ptr_wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        hw_active,
    input  logic        hw_err,
    input  logic        hw_irq,
    output logic [7:0]  cmd_byte,
    output logic [7:0]  stat_byte,
    output logic [31:0] ptr,
    output logic        start,
    output logic        dir
);

    logic        start_q, dir_q;
    logic        act_q, err_q, irq_q;
    logic [1:0]  free_q;
    logic [31:2] ptr_q;

    logic        start_d, dir_d, err_d, irq_d;
    logic [1:0]  free_d;
    logic [31:2] ptr_d;
    logic [7:0]  cmd_w, stat_w;
    stat_t       stat_view;

    assign cmd_w  = wdata[8*LANE_CMD  +: 8];
    assign stat_w = wdata[8*LANE_STAT +: 8];

    // Next-state for command, status and pointer from bus and hardware.
    always_comb begin
        start_d = start_q;
        dir_d   = dir_q;
        err_d   = err_q;
        irq_d   = irq_q;
        free_d  = free_q;
        ptr_d   = ptr_q;
        if (ctl_wr && be[LANE_CMD]) begin
            start_d = cmd_w[CMD_START_BIT];
            dir_d   = cmd_w[CMD_DIR_BIT];
        end
        if (ctl_wr && be[LANE_STAT]) begin
            free_d = stat_w[ST_FREE_LO +: 2];
            err_d  = err_q & ~stat_w[ST_ERR_BIT];
            irq_d  = irq_q & ~stat_w[ST_IRQ_BIT];
        end
        if (hw_err) err_d = 1'b1;
        if (hw_irq) irq_d = 1'b1;
        if (ptr_wr) ptr_d = ptr_merge(ptr_q, wdata, be);
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            act_q   <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            free_q  <= 2'b00;
            ptr_q   <= '0;
        end else begin
            start_q <= start_d;
            dir_q   <= dir_d;
            act_q   <= hw_active;
            err_q   <= err_d;
            irq_q   <= irq_d;
            free_q  <= free_d;
            ptr_q   <= ptr_d;
        end
    end

    // Assemble the software view of the status byte.
    always_comb begin
        stat_view       = '0;
        stat_view.act   = act_q;
        stat_view.err   = err_q;
        stat_view.irq   = irq_q;
        stat_view.free  = free_q;
    end

    // Assemble the command byte and drive engine-facing outputs.
    always_comb begin
        cmd_byte                = '0;
        cmd_byte[CMD_START_BIT] = start_q;
        cmd_byte[CMD_DIR_BIT]   = dir_q;
    end

    assign stat_byte = stat_view;
    assign ptr       = {ptr_q, 2'b00};
    assign start     = start_q;
    assign dir       = dir_q;

endmodule

// File: rtl/ide_bm_rdmux.sv
// Module: registered read-data multiplexer across all channel slices.
// Assumes NUM_CH is a power of two, at least 2; pad lanes return 0xFF.
module ide_bm_rdmux
    import ide_bm_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH * CH_BYTES),
    localparam int CH_W   = ADDR_W - CH_OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic [ADDR_W-1:2]     rd_addr,
    input  logic [NUM_CH*8-1:0]   cmd_all,
    input  logic [NUM_CH*8-1:0]   stat_all,
    input  logic [NUM_CH*32-1:0]  ptr_all,
    output logic [31:0]           rdata
);

    logic [CH_W-1:0] ch_idx;
    logic [31:0]     rd_next;

    assign ch_idx = rd_addr[ADDR_W-1:CH_OFS_W];

    // Select the addressed dword of the addressed channel.
    always_comb begin
        if (rd_addr[2]) begin
            rd_next = ptr_all[int'(ch_idx)*32 +: 32];
        end else begin
            rd_next = {PAD_BYTE, stat_all[int'(ch_idx)*8 +: 8],
                       PAD_BYTE, cmd_all[int'(ch_idx)*8 +: 8]};
        end
    end

    // Capture read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_next;
    end

endmodule

// File: rtl/ide_bm_regs.sv
// Module: top of the bus-master IDE DMA register block. Decodes the
// register window into per-channel slices and gathers read data.
// Assumes one access per strobe and NUM_CH a power of two, at least 2.
module ide_bm_regs
    import ide_bm_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH * CH_BYTES),
    localparam int CH_W   = ADDR_W - CH_OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:2]     bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_CH-1:0]     dma_active,
    input  logic [NUM_CH-1:0]     err_set,
    input  logic [NUM_CH-1:0]     irq_set,
    output logic [NUM_CH-1:0]     dma_start,
    output logic [NUM_CH-1:0]     dma_dir,
    output logic [NUM_CH*32-1:0]  prd_addr
);

    logic [NUM_CH*8-1:0]  cmd_all;
    logic [NUM_CH*8-1:0]  stat_all;
    logic [NUM_CH*32-1:0] ptr_all;

    // One register slice per channel with its own write decode.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit, ctl_wr, ptr_wr;
        assign hit    = (bus_addr[ADDR_W-1:CH_OFS_W] == CH_W'(c));
        assign ctl_wr = bus_wr && hit && !bus_addr[2];
        assign ptr_wr = bus_wr && hit &&  bus_addr[2];

        ide_bm_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_wr),
            .ptr_wr    (ptr_wr),
            .be        (bus_be),
            .wdata     (bus_wdata),
            .hw_active (dma_active[c]),
            .hw_err    (err_set[c]),
            .hw_irq    (irq_set[c]),
            .cmd_byte  (cmd_all[c*8 +: 8]),
            .stat_byte (stat_all[c*8 +: 8]),
            .ptr       (ptr_all[c*32 +: 32]),
            .start     (dma_start[c]),
            .dir       (dma_dir[c])
        );
    end

    ide_bm_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .rd_addr  (bus_addr),
        .cmd_all  (cmd_all),
        .stat_all (stat_all),
        .ptr_all  (ptr_all),
        .rdata    (bus_rdata)
    );

    assign prd_addr = ptr_all;

endmodule

// File: rtl/ide_bm_regs_chk.sv
// Module: property checker for ide_bm_regs, attached by bind below.
// Assumes the status bytes are visible as a flat vector, channel 0 lowest.
module ide_bm_regs_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd,
    input logic                 rd_ptr,
    input logic                 stat_wr,
    input logic [31:0]          rdata,
    input logic [NUM_CH-1:0]    dma_active,
    input logic [NUM_CH-1:0]    err_set,
    input logic [NUM_CH-1:0]    irq_set,
    input logic [NUM_CH*8-1:0]  stat_all
);

    // R1: read data changes only after a read strobe
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$past(rd)) |-> $stable(rdata));

    // R3: command/status dword reads carry 0xFF in the pad lanes
    p_pad_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rd_ptr) |=> (rdata[15:8] == 8'hFF && rdata[31:24] == 8'hFF));

    // R8: pointer reads are dword aligned
    p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rd_ptr) |=> (rdata[1:0] == 2'b00));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R5: status bit 0 mirrors the engine's running level one edge late
        p_active_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && $past(rst_n)) |-> (stat_all[c*8] == $past(dma_active[c])));

        // R6: a hardware error pulse always leaves the error flag set
        p_err_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            err_set[c] |=> stat_all[c*8+1]);

        // R6: a hardware interrupt pulse always leaves the interrupt flag set
        p_irq_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_set[c] |=> stat_all[c*8+2]);

        // R7: reserved status bits stay zero
        p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_all[c*8+7] == 1'b0 && stat_all[c*8+4 -: 2] == 2'b00));

        // R4: free status bits move only on a status-lane write
        p_free_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && $past(rst_n) && !$past(stat_wr)) |-> $stable(stat_all[c*8+5 +: 2]));
    end

endmodule

bind ide_bm_regs ide_bm_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .rd_ptr     (bus_addr[2]),
    .stat_wr    (bus_wr && bus_be[2] && !bus_addr[2]),
    .rdata      (bus_rdata),
    .dma_active (dma_active),
    .err_set    (err_set),
    .irq_set    (irq_set),
    .stat_all   (stat_all)
);

// File: tb/ide_bm_regs_bench.sv
module ide_bm_regs_bench;

    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:2]        bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    dma_active = '0;
    logic [NCH-1:0]    err_set = '0;
    logic [NCH-1:0]    irq_set = '0;
    logic [NCH-1:0]    dma_start;
    logic [NCH-1:0]    dma_dir;
    logic [NCH*32-1:0] prd_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ide_bm_regs #(.NUM_CH(NCH)) u_ide_bm_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .dma_active(dma_active), .err_set(err_set),
        .irq_set(irq_set), .dma_start(dma_start), .dma_dir(dma_dir),
        .prd_addr(prd_addr)
    );

    // Vector table: optional write, then a read and its expected dword.
    localparam int NV = 10;
    localparam bit          V_WR   [NV] = '{1,1,1,1,1,1,0,1,1,1};
    localparam logic [3:0]  V_WA   [NV] = '{4'h0,4'h0,4'h0,4'h4,4'h4,4'hC,4'h0,4'h8,4'h8,4'h8};
    localparam logic [3:0]  V_BE   [NV] = '{4'h1,4'h4,4'h4,4'hF,4'h2,4'hC,4'h0,4'h1,4'h1,4'h1};
    localparam logic [31:0] V_WD   [NV] = '{32'h000000FF, 32'h00FF0000, 32'h00000000,
                                            32'h12345677, 32'h0000AB00, 32'hCAFE0000,
                                            32'h00000000, 32'h000000F6, 32'h00000008,
                                            32'h00000001};
    localparam logic [3:0]  V_RA   [NV] = '{4'h0,4'h0,4'h0,4'h4,4'h4,4'hC,4'h4,4'h8,4'h8,4'h8};
    localparam logic [31:0] V_EXP  [NV] = '{32'hFF00FF09, 32'hFF60FF09, 32'hFF00FF09,
                                            32'h12345674, 32'h1234AB74, 32'hCAFE0000,
                                            32'h1234AB74, 32'hFF00FF00, 32'hFF00FF08,
                                            32'hFF00FF01};
    // Requirement per row: R2 R4 R4 R8 R8 R8 R10 R2 R2 R1
    localparam int          V_REQ  [NV] = '{2,4,4,8,8,8,10,2,2,1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[3:2]; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[3:2]; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        do_reset();

        // R9: reset state at the ports and through reads
        chk("R9 start", 32'(dma_start), 32'h0);
        chk("R9 prd0", prd_addr[31:0], 32'h0);
        bus_read(4'h0, rv); chk("R9 ch0 ctl", rv, 32'hFF00FF00);
        bus_read(4'hC, rv); chk("R9 ch1 ptr", rv, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) bus_write(V_WA[i], V_BE[i], V_WD[i]);
            bus_read(V_RA[i], rv);
            chk($sformatf("R%0d vec %0d", V_REQ[i], i), rv, V_EXP[i]);
        end

        // R2: engine-facing command bits
        chk("R2 start", 32'(dma_start), 32'h3);
        chk("R2 dir", 32'(dma_dir), 32'h1);
        // R8: pointer outputs
        chk("R8 prd0", prd_addr[31:0], 32'h1234AB74);
        chk("R8 prd1", prd_addr[63:32], 32'hCAFE0000);

        // R6: hardware set and write-one-to-clear on channel 0
        @(negedge clk); err_set = 2'b01; @(negedge clk); err_set = '0;
        bus_read(4'h0, rv); chk("R6 err set", 32'(rv[23:16]), 32'h02);
        @(negedge clk); irq_set = 2'b01; @(negedge clk); irq_set = '0;
        bus_read(4'h0, rv); chk("R6 irq set", 32'(rv[23:16]), 32'h06);
        bus_write(4'h0, 4'h4, 32'h00020000);
        bus_read(4'h0, rv); chk("R6 w1c err", 32'(rv[23:16]), 32'h04);
        chk("R2 cmd kept", 32'(rv[7:0]), 32'h09);
        // R6: set pulse and clearing write in the same cycle
        @(negedge clk);
        bus_addr = 2'b00; bus_be = 4'h4; bus_wdata = 32'h00040000; bus_wr = 1'b1;
        irq_set = 2'b01;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; irq_set = '0;
        bus_read(4'h0, rv); chk("R6 set wins", 32'(rv[23:16]), 32'h04);
        bus_write(4'h0, 4'h4, 32'h00040000);
        bus_read(4'h0, rv); chk("R6 w1c irq", 32'(rv[23:16]), 32'h00);
        // R10: channel 1 status untouched by channel 0 activity
        bus_read(4'h8, rv); chk("R10 ch1 stat", 32'(rv[23:16]), 32'h00);

        // R5 / R4 / R7: running mirror, free bits, reserved bits
        @(negedge clk); dma_active = 2'b10; @(negedge clk);
        bus_read(4'h8, rv); chk("R5 active", 32'(rv[23:16]), 32'h01);
        bus_write(4'h8, 4'h4, 32'h00FF0000);
        bus_read(4'h8, rv); chk("R5 R4 R7 write ff", 32'(rv[23:16]), 32'h61);
        @(negedge clk); dma_active = 2'b00; @(negedge clk);
        bus_read(4'h8, rv); chk("R5 idle", 32'(rv[23:16]), 32'h60);

        // R9: reset mid-run clears everything
        do_reset();
        chk("R9 start after", 32'(dma_start), 32'h0);
        chk("R9 prd1 after", prd_addr[63:32], 32'h0);
        bus_read(4'h8, rv); chk("R9 ch1 ctl after", rv, 32'hFF00FF00);
        bus_read(4'h4, rv); chk("R9 ch0 ptr after", rv, 32'h0);

        finish_run();
    end

endmodule